// File: doc/BRIEF.md
# Streaming Cell Greeting Rewriter

This block sits inline on a 32-bit cell stream that carries one word per clock. A start-of-cell strobe marks the first word of each 14-word cell. Word 0 is the header. Word 1 is a pad word. Words 2 through 13 carry the payload, with the first character of each word in its most significant byte. On cells whose channel identifier (header bits [19:4]) equals 5, the block looks for the text "HELLO" at the start of the payload. When it finds it, that text is rewritten to "WORLD.". Every other cell, and every other word of a matching cell, leaves the block exactly as it arrived.

The final compared character sits in the second payload word. For this reason, both data and start-of-cell pass through a fixed two-cycle pipeline. The first payload word can then be released, either replaced or original, only after the next word has been examined. When no cell is in progress, the output word is forced to zero.

The stream has no stall of its own. Back-pressure is handled only by the cell-available indicator. The downstream indicator is wired straight to the upstream output, so an upstream source that honours it never overruns the block. The block never adds, drops or holds back whole cells.

Top module: `scell_rewrite`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_data` is zero and `out_soc` is low.
- R2: When no cell is in progress, `out_data` is all zeros two cycles later, whatever `in_data` carries.
- R3: Every word and its start-of-cell flag appear on `out_data`/`out_soc` exactly two clock cycles after they are presented at the input.
- R4: A cell whose channel field (header bits [19:4]) is not 5 is forwarded with all 14 words unchanged, even when its payload begins with "HELLO".
- R5: A cell on channel 5 is rewritten when payload word 0 equals 32'h48454C4C ("HELL") and payload word 1 has 8'h4F ("O") in bits [31:24]. Payload word 0 then leaves as 32'h574F524C ("WORL"). Payload word 1 leaves with bits [31:16] = 16'h442E ("D.") and bits [15:0] as received.
- R6: On channel 5, a difference in any byte of payload word 0 from "HELL" (for example "MELL") leaves the whole cell unchanged.
- R7: On channel 5 with "HELL" matched, a top byte of payload word 1 other than 8'h4F leaves the whole cell unchanged.
- R8: In a rewritten cell, the header, the pad word and payload words 2 to 11 are forwarded unchanged.
- R9: A start-of-cell on the cycle right after word 13 starts the next cell at once, and each of the back-to-back cells is judged and rewritten on its own.
- R10: `up_cell_avail` always equals `dn_cell_avail` in the same cycle.
- R11: Only header bits [19:4] decide the channel. Nonzero header bits outside that field do not stop a match, and the value 16'h0015 is not treated as channel 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 32 | Incoming cell word |
| in_soc | input | 1 | High during the first word of an incoming cell |
| dn_cell_avail | input | 1 | Cell-available indicator from downstream |
| up_cell_avail | output | 1 | Cell-available indicator toward upstream |
| out_data | output | 32 | Outgoing word, two cycles behind the input |
| out_soc | output | 1 | Start-of-cell aligned with `out_data` |

## Verification
The hardest case to reach is a full match whose replacement straddles back-to-back cells. The pipeline is still releasing the tail of one cell while the header of the next cell is already being judged. The stimulus sends matching cells with no idle gap between them, and then mixes matching and non-matching cells. The near-miss payloads "MELL" and "HELL" followed by a wrong fifth byte check that the state of one cell's comparison never carries into the next.

// File: rtl/scell_pkg.sv
package scell_pkg;
  // Comparison stages of one cell.
  typedef enum logic [2:0] {
    M_IDLE,
    M_PAD,
    M_HELL,
    M_OCHK,
    M_PASS
  } mstate_t;

  localparam logic [31:0] TXT_HELL = 32'h48454C4C;
  localparam logic [7:0]  TXT_O    = 8'h4F;
  localparam logic [31:0] TXT_WORL = 32'h574F524C;
  localparam logic [15:0] TXT_DDOT = 16'h442E;
endpackage

// File: rtl/scell_framer.sv
module scell_framer #(
  parameter int CELL_WORDS = 14,
  localparam int IDX_W = $clog2(CELL_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_soc,
  output logic             cur_valid,
  output logic [IDX_W-1:0] cur_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_WORDS - 1);

  logic             busy;
  logic [IDX_W-1:0] idx;

  assign cur_valid = in_soc | busy;
  assign cur_idx   = in_soc ? '0 : idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (cur_valid) begin
      if (cur_idx == LAST) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        busy <= 1'b1;
        idx  <= cur_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scell_matcher.sv
module scell_matcher
  import scell_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int VCI_LSB   = 4,
  parameter int VCI_W     = 16,
  parameter int VCI_VALUE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cur_valid,
  input  logic              in_soc,
  input  logic [DATA_W-1:0] in_data,
  output logic              hit
);
  localparam logic [VCI_W-1:0] VCI_K = VCI_W'(VCI_VALUE);

  mstate_t state, nxt;
  logic    vci_ok, hell_ok, o_ok;

  assign vci_ok  = (in_data[VCI_LSB +: VCI_W] == VCI_K);
  assign hell_ok = (in_data[31:0] == TXT_HELL);
  assign o_ok    = (in_data[31:24] == TXT_O);

  always_comb begin
    nxt = state;
    if (in_soc) begin
      nxt = vci_ok ? M_PAD : M_PASS;
    end else if (!cur_valid) begin
      nxt = M_IDLE;
    end else begin
      case (state)
        M_PAD:   nxt = M_HELL;
        M_HELL:  nxt = hell_ok ? M_OCHK : M_PASS;
        M_OCHK:  nxt = M_PASS;
        default: nxt = state;
      endcase
    end
  end

  assign hit = cur_valid && !in_soc && (state == M_OCHK) && o_ok;

  always_ff @(posedge clk) begin
    if (rst) state <= M_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/scell_delay.sv
module scell_delay
  import scell_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cur_valid,
  input  logic              in_soc,
  input  logic              hit,
  output logic [DATA_W-1:0] out_data,
  output logic              out_soc
);
  logic [DATA_W-1:0] s1_data;
  logic              s1_vld, s1_soc, tail_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_data   <= '0;
      s1_vld    <= 1'b0;
      s1_soc    <= 1'b0;
      out_data  <= '0;
      out_soc   <= 1'b0;
      tail_pend <= 1'b0;
    end else begin
      s1_data   <= in_data;
      s1_vld    <= cur_valid;
      s1_soc    <= in_soc;
      out_soc   <= s1_soc;
      tail_pend <= hit;
      if (!s1_vld)        out_data <= '0;
      else if (hit)       out_data <= DATA_W'(TXT_WORL);
      else if (tail_pend) out_data <= {TXT_DDOT, s1_data[15:0]};
      else                out_data <= s1_data;
    end
  end
endmodule

// File: rtl/scell_rewrite.sv
module scell_rewrite #(
  parameter int CELL_WORDS = 14,
  parameter int VCI_LSB    = 4,
  parameter int VCI_W      = 16,
  parameter int VCI_VALUE  = 5,
  localparam int DATA_W    = 32,
  localparam int IDX_W     = $clog2(CELL_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_soc,
  input  logic              dn_cell_avail,
  output logic              up_cell_avail,
  output logic [DATA_W-1:0] out_data,
  output logic              out_soc
);
  logic             cur_valid;
  logic [IDX_W-1:0] cur_idx;
  logic             match_hit;

  assign up_cell_avail = dn_cell_avail;

  scell_framer #(.CELL_WORDS(CELL_WORDS)) u_frm (
    .clk(clk), .rst(rst), .in_soc(in_soc),
    .cur_valid(cur_valid), .cur_idx(cur_idx)
  );

  scell_matcher #(
    .DATA_W(DATA_W), .VCI_LSB(VCI_LSB), .VCI_W(VCI_W), .VCI_VALUE(VCI_VALUE)
  ) u_mat (
    .clk(clk), .rst(rst), .cur_valid(cur_valid), .in_soc(in_soc),
    .in_data(in_data), .hit(match_hit)
  );

  scell_delay #(.DATA_W(DATA_W)) u_dly (
    .clk(clk), .rst(rst), .in_data(in_data), .cur_valid(cur_valid),
    .in_soc(in_soc), .hit(match_hit), .out_data(out_data), .out_soc(out_soc)
  );
endmodule

// File: rtl/scell_rewrite_chk.sv
module scell_rewrite_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_soc,
  input logic        out_soc,
  input logic [31:0] out_data,
  input logic        match_hit
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)           age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1: the outputs are cleared on the edge where reset is released
  p_reset_clear_r1: assert property (@(posedge clk)
    $fell(rst) |-> (out_data == 32'h0 && !out_soc));

  // R3: the start-of-cell flag trails the input by two cycles
  p_soc_delay_r3: assert property (@(posedge clk) disable iff (rst || age < 2'd2)
    out_soc == $past(in_soc, 2));

  // R5: a detected match releases "WORL" next
  p_worl_after_hit_r5: assert property (@(posedge clk) disable iff (rst)
    match_hit |=> (out_data == 32'h574F524C));

  // R5: then the upper half of the following word becomes "D."
  p_ddot_tail_r5: assert property (@(posedge clk) disable iff (rst)
    match_hit |=> ##1 (out_data[31:16] == 16'h442E));

  // R5: a match is a single-cycle event within a cell
  p_hit_single_r5: assert property (@(posedge clk) disable iff (rst)
    match_hit |=> !match_hit);
endmodule

bind scell_rewrite scell_rewrite_chk u_chk (
  .clk(clk), .rst(rst), .in_soc(in_soc), .out_soc(out_soc),
  .out_data(out_data), .match_hit(match_hit)
);

// File: tb/scell_rewrite_tb.sv
module scell_rewrite_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] in_data = 32'h0;
  logic        in_soc = 1'b0;
  logic        dn_cell_avail = 1'b0;
  logic        up_cell_avail;
  logic [31:0] out_data;
  logic        out_soc;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] ring_d [4];
  logic        ring_s [4];
  int          ring_r [4];
  bit          ring_v [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  scell_rewrite u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_soc(in_soc),
    .dn_cell_avail(dn_cell_avail), .up_cell_avail(up_cell_avail),
    .out_data(out_data), .out_soc(out_soc)
  );

  task automatic check(input bit ok, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // One clock: compare outputs against the word from two steps earlier (R3),
  // then present the next input word with its expected output.
  task automatic step(input logic [31:0] d, input logic s,
                      input logic [31:0] ed, input int req);
    int k;
    @(negedge clk);
    if (cyc >= 2) begin
      k = (cyc - 2) % 4;
      if (ring_v[k]) begin
        check(out_data === ring_d[k], ring_r[k], out_data, ring_d[k]);
        check(out_soc === ring_s[k], 3, {31'h0, out_soc}, {31'h0, ring_s[k]});
      end
    end
    in_data = d;
    in_soc  = s;
    k = cyc % 4;
    ring_d[k] = ed;
    ring_s[k] = s;
    ring_r[k] = req;
    ring_v[k] = 1'b1;
    cyc++;
  endtask

  // R2: idle words with junk data must leave as zero
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(32'hDEAD_0000 + i, 1'b0, 32'h0, 2);
  endtask

  // Builds a 14-word cell; rewrite tells whether R5 substitution is expected.
  task automatic send_cell(input logic [31:0] hdr, input logic [31:0] p0,
                           input logic [31:0] p1, input bit rewrite, input int req);
    step(hdr, 1'b1, hdr, req);
    step(32'h0000_00A5, 1'b0, 32'h0000_00A5, req);
    step(p0, 1'b0, rewrite ? 32'h574F524C : p0, rewrite ? 5 : req);
    step(p1, 1'b0, rewrite ? {16'h442E, p1[15:0]} : p1, rewrite ? 5 : req);
    for (int i = 0; i < 10; i++)
      step(32'h3000_0000 + (i << 8) + hdr[7:0], 1'b0,
           32'h3000_0000 + (i << 8) + hdr[7:0], rewrite ? 8 : req);
  endtask

  // R1: reset state
  task automatic t_reset();
    rst = 1'b1;
    in_data = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check(out_data === 32'h0, 1, out_data, 32'h0);
    check(out_soc === 1'b0, 1, {31'h0, out_soc}, 32'h0);
    rst = 1'b0;
    in_data = 32'h0;
    @(negedge clk);
    check(out_data === 32'h0, 1, out_data, 32'h0);
    for (int i = 0; i < 4; i++) ring_v[i] = 1'b0;
  endtask

  // R4: HELLO on channel 6 passes unchanged
  task automatic t_off_channel();
    send_cell(32'h0000_0060, 32'h48454C4C, 32'h4F2C_2021, 1'b0, 4);
    idle(3);
  endtask

  // R5 and R8: full match on channel 5
  task automatic t_match();
    send_cell(32'h0000_0050, 32'h48454C4C, 32'h4F21_3344, 1'b1, 5);
    idle(3);
  endtask

  // R6: first byte wrong ("MELL")
  task automatic t_mello();
    send_cell(32'h0000_0050, 32'h4D454C4C, 32'h4F21_3344, 1'b0, 6);
    idle(2);
  endtask

  // R7: "HELL" followed by a wrong fifth character
  task automatic t_no_o();
    send_cell(32'h0000_0050, 32'h48454C4C, 32'h4E21_3344, 1'b0, 7);
    idle(2);
  endtask

  // R11: only bits [19:4] select the channel
  task automatic t_field();
    send_cell(32'hABC0_005F, 32'h48454C4C, 32'h4F00_7788, 1'b1, 11);
    idle(1);
    send_cell(32'h0000_0150, 32'h48454C4C, 32'h4F00_7788, 1'b0, 11);
    idle(2);
  endtask

  // R9: back-to-back cells, mixed results
  task automatic t_back_to_back();
    send_cell(32'h0000_0050, 32'h48454C4C, 32'h4F11_2233, 1'b1, 9);
    send_cell(32'h0000_0051, 32'h48454C4C, 32'h4F44_5566, 1'b1, 9);
    send_cell(32'h0000_0070, 32'h48454C4C, 32'h4F77_8899, 1'b0, 9);
    send_cell(32'h0000_0052, 32'h48454C4C, 32'h4FAA_BBCC, 1'b1, 9);
    idle(3);
  endtask

  // R10: flow-control pass-through
  task automatic t_flow();
    for (int i = 0; i < 4; i++) begin
      dn_cell_avail = i[0];
      #1;
      check(up_cell_avail === i[0], 10, {31'h0, up_cell_avail}, {31'h0, i[0]});
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) ring_v[i] = 1'b0;
    t_reset();
    idle(4);
    t_flow();
    t_off_channel();
    t_match();
    t_mello();
    t_no_o();
    t_field();
    t_back_to_back();
    idle(2);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule